// File: doc/BRIEF.md
# USB Packet Stream Monitor

This block watches a byte stream that has already been NRZI-decoded and de-stuffed. Every byte arrives with a valid strobe, and flags mark the first and last byte of each packet. The block never drives the bus. For each accepted byte it emits one monitor record, one cycle later. The first byte of a packet gives a header record that carries the PID byte. Every later byte gives a data record that carries the byte value. The last record of a packet also carries a verdict on the packet's integrity.

The PID selects how a packet is judged:

- **Tokens** must be three bytes long and pass a 5-bit CRC.
- **Data packets** need a PID, any number of payload bytes, and a 16-bit CRC that must pass.
- **Handshakes** must be a lone PID byte.
- **Special packets** are passed through without a check.

The monitor also remembers the endpoint named by the last good IN, OUT or SETUP token. It keeps the DATA0/DATA1 value it expects next for each endpoint, and it flags a data packet whose toggle is out of step. Such a packet usually means a packet was lost or repeated.

Top module: `usb_pkt_monitor`

## Requirements
- R1: After reset no record is valid, the current endpoint is 0, and every endpoint expects DATA0 next.
- R2: Each byte accepted into a packet yields exactly one record one clock later with recValid=1, in arrival order. The first byte gives recHeader=1 and the later bytes give recHeader=0. recValue equals the byte. Cycles with inValid=0 inside a packet add no record.
- R3: A byte with inValid=1 and inStart=0 while no packet is open is ignored and yields no record.
- R4: A PID byte is bad when its bits [7:4] are not the ones-complement of its bits [3:0], or when bits [3:0] are 0000. A bad PID sets recPidErr=1 on the header record and gives status 3 (format error) on the packet's last record.
- R5: A token has PID bits [1:0]=01: OUT 0001, IN 1001, SOF 0101, SETUP 1101. It must be exactly 3 bytes long, or its status is 3. The CRC5 uses x^5+x^2+1, starts at all ones, and covers bits of bytes 1 and 2 taken least significant bit first. A residual of 01100 gives status 1 (normal); any other residual gives status 2 (CRC error).
- R6: A data packet has PID bits [1:0]=11: DATA0 0011, DATA1 1011, DATA2 0111, MDATA 1111. It must be at least 3 bytes long, or its status is 3. The CRC16 uses x^16+x^15+x^2+1, starts at all ones, and covers all bytes after the PID. A residual of 0x800D gives status 1; any other residual gives status 2.
- R7: A handshake has PID bits [1:0]=10: ACK 0010, NAK 1010, STALL 1110, NYET 0110. A lone byte gives status 1 and any other length gives status 3.
- R8: A special packet has PID bits [1:0]=00 with a nonzero code. It gets status 1 on its last record at any length, with no CRC check.
- R9: recStatus is 0 on every record except the last record of a packet, and is 0 whenever recValid is 0.
- R10: A good IN or OUT or SETUP token (status 1) sets the current endpoint. The endpoint is bit 7 of byte 1 as its LSB, followed by bits [2:0] of byte 2. A DATA0 or DATA1 header whose toggle differs from the value expected for the current endpoint sets recSeqErr=1. A DATA0/DATA1 packet with status 1 makes that endpoint expect the opposite toggle. A packet with a bad CRC leaves the expectation unchanged.
- R11: A good SETUP token forces its endpoint to expect DATA0 next.
- R12: Toggle expectations are held separately for each of 16 endpoints, and a SOF token leaves the current endpoint unchanged.
- R13: inStart while a packet is open abandons that packet without a final status and opens a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A byte is present this cycle |
| inStart | input | 1 | The byte is the first byte (PID) of a packet |
| inEnd | input | 1 | The byte is the last byte of a packet |
| inByte | input | 8 | Decoded byte, bit 0 first on the wire |
| recValid | output | 1 | A monitor record is present |
| recHeader | output | 1 | 1 = packet header record, 0 = data byte record |
| recValue | output | 8 | PID byte or data byte |
| recStatus | output | 2 | 0 none, 1 normal, 2 CRC error, 3 format error |
| recPidErr | output | 1 | PID check failed (header records only) |
| recSeqErr | output | 1 | DATA0/DATA1 out of step (header records only) |

## Verification
The bench aims at the following corner cases, and names the wrong behaviour each one would expose:

- **Packet length edges.** It sends 2- and 4-byte tokens, a data packet with an empty payload, a 2-byte data packet and a 2-byte handshake. A design with an off-by-one length counter, or one that checks the CRC before it checks the length, would give the wrong verdict on these.
- **Corrupted CRCs.** It sends tokens and data packets with one CRC bit flipped. A design using the wrong residual or bit order would either accept them or reject good packets.
- **Toggle state.** It walks toggle tracking across several endpoints, a SETUP reset, a SOF between transactions and a data packet with a bad CRC. A design that shared one toggle bit between endpoints, let a SOF change the endpoint, or advanced the toggle on a corrupt packet would raise false sequence errors or miss real ones.
- **Stream framing.** It sends stray bytes, mid-packet gaps and a restart inside an open packet. A design that mishandled these would emit extra records or put a status on an abandoned packet.

// File: rtl/usbmon_pkg.sv
`timescale 1ns/1ps
package usbmon_pkg;

  typedef enum logic [1:0] {
    CLS_SPECIAL   = 2'b00,
    CLS_TOKEN     = 2'b01,
    CLS_HANDSHAKE = 2'b10,
    CLS_DATA      = 2'b11
  } pidClass_e;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_OK     = 2'd1,
    ST_CRC    = 2'd2,
    ST_FORMAT = 2'd3
  } recStatus_e;

  localparam logic [3:0]  PID_SOF        = 4'b0101;
  localparam logic [3:0]  PID_SETUP      = 4'b1101;
  localparam logic [4:0]  CRC5_RESIDUAL  = 5'b01100;
  localparam logic [15:0] CRC16_RESIDUAL = 16'h800D;

  // strobes from control to datapath
  typedef struct packed {
    logic       acc;     // byte belongs to a packet
    logic       first;   // PID byte
    logic       last;    // closing byte
    logic [3:0] pid;     // PID code of the open packet
    logic       pidBad;  // PID failed its check
  } strobe_t;

  function automatic logic [4:0] crc5Byte(input logic [4:0] c, input logic [7:0] d);
    logic [4:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = d[i] ^ r[4];
      r  = {r[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    return r;
  endfunction

  function automatic logic [15:0] crc16Byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = d[i] ^ r[15];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/usbmon_ctrl.sv
`timescale 1ns/1ps
module usbmon_ctrl
  import usbmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  input  logic [7:0] inByte,
  output strobe_t    strb
);

  logic       inPkt;
  logic [3:0] pidReg;
  logic       pidBadReg;
  logic       byteBad;

  assign byteBad = (inByte[7:4] != ~inByte[3:0]) || (inByte[3:0] == 4'b0000);

  always_comb begin
    strb.first  = inValid && inStart;
    strb.acc    = inValid && (inStart || inPkt);
    strb.last   = strb.acc && inEnd;
    strb.pid    = strb.first ? inByte[3:0] : pidReg;
    strb.pidBad = strb.first ? byteBad : pidBadReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      pidReg    <= 4'd0;
      pidBadReg <= 1'b0;
    end else begin
      if (strb.first) begin
        pidReg    <= inByte[3:0];
        pidBadReg <= byteBad;
      end
      if (strb.acc) inPkt <= !inEnd;
    end
  end

  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inStart && !inPkt) |-> !strb.acc); // R3

endmodule

// File: rtl/usbmon_dpath.sv
`timescale 1ns/1ps
module usbmon_dpath
  import usbmon_pkg::*;
#(
  parameter int EP_COUNT = 16,
  parameter int LEN_W    = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [7:0] inByte,
  output logic       recValid,
  output logic       recHeader,
  output logic [7:0] recValue,
  output logic [1:0] recStatus,
  output logic       recPidErr,
  output logic       recSeqErr
);

  localparam int EP_W = $clog2(EP_COUNT);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0]    lenReg, lenNow;
  logic [4:0]          crc5Reg, crc5Next;
  logic [15:0]         crc16Reg, crc16Next;
  logic                epLsbReg;
  logic [3:0]          epField;
  logic [EP_W-1:0]     curEp;
  logic [EP_COUNT-1:0] expTog;
  pidClass_e           cls;
  recStatus_e          endStatus;
  logic                isToggleData, seqHit, tokOk, dataOk;

  assign cls          = pidClass_e'(strb.pid[1:0]);
  assign lenNow       = strb.first ? LEN_W'(1) :
                        ((lenReg == LEN_MAX) ? LEN_MAX : lenReg + 1'b1);
  assign crc5Next     = crc5Byte(crc5Reg, inByte);
  assign crc16Next    = crc16Byte(crc16Reg, inByte);
  assign epField      = {inByte[2:0], epLsbReg};
  assign isToggleData = (cls == CLS_DATA) && !strb.pid[2];
  assign seqHit       = strb.first && !strb.pidBad && isToggleData &&
                        (strb.pid[3] != expTog[curEp]);

  // verdict for the byte that closes the packet
  always_comb begin
    endStatus = ST_OK;
    if (strb.pidBad) endStatus = ST_FORMAT;
    else begin
      case (cls)
        CLS_TOKEN: begin
          if (lenNow != LEN_W'(3))            endStatus = ST_FORMAT;
          else if (crc5Next != CRC5_RESIDUAL) endStatus = ST_CRC;
        end
        CLS_DATA: begin
          if (lenNow < LEN_W'(3))               endStatus = ST_FORMAT;
          else if (crc16Next != CRC16_RESIDUAL) endStatus = ST_CRC;
        end
        CLS_HANDSHAKE: if (lenNow != LEN_W'(1)) endStatus = ST_FORMAT;
        default: endStatus = ST_OK;
      endcase
    end
  end

  assign tokOk  = strb.last && (cls == CLS_TOKEN) && (endStatus == ST_OK) &&
                  (strb.pid != PID_SOF);
  assign dataOk = strb.last && isToggleData && (endStatus == ST_OK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= '0;
      crc5Reg   <= '1;
      crc16Reg  <= '1;
      epLsbReg  <= 1'b0;
      curEp     <= '0;
      expTog    <= '0;
      recValid  <= 1'b0;
      recHeader <= 1'b0;
      recValue  <= 8'd0;
      recStatus <= ST_NONE;
      recPidErr <= 1'b0;
      recSeqErr <= 1'b0;
    end else begin
      if (strb.acc) begin
        lenReg <= lenNow;
        if (strb.first) begin
          crc5Reg  <= '1;
          crc16Reg <= '1;
        end else begin
          crc5Reg  <= crc5Next;
          crc16Reg <= crc16Next;
        end
        if (lenNow == LEN_W'(2)) epLsbReg <= inByte[7];
      end
      if (tokOk) begin
        curEp <= epField[EP_W-1:0];
        if (strb.pid == PID_SETUP) expTog[epField[EP_W-1:0]] <= 1'b0;
      end
      if (dataOk) expTog[curEp] <= !strb.pid[3];
      recValid  <= strb.acc;
      recHeader <= strb.first;
      recValue  <= inByte;
      recStatus <= strb.last ? endStatus : ST_NONE;
      recPidErr <= strb.first && strb.pidBad;
      recSeqErr <= seqHit;
    end
  end

  AST_STATUS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !recValid |-> recStatus == ST_NONE); // R9
  AST_MID_NO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acc && !strb.last) |=> (recValid && recStatus == ST_NONE)); // R9
  AST_PIDERR_ON_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    recPidErr |-> recHeader); // R4
  AST_BADPID_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && strb.pidBad) |=> recStatus == ST_FORMAT); // R4
  AST_SEQERR_ON_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    recSeqErr |-> (recHeader && !recPidErr)); // R10
  AST_LONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.first && strb.last && !strb.pidBad && strb.pid[1:0] == 2'b10)
      |=> recStatus == ST_OK); // R7

endmodule

// File: rtl/usb_pkt_monitor.sv
`timescale 1ns/1ps
module usb_pkt_monitor
  import usbmon_pkg::*;
#(
  parameter int EP_COUNT = 16,
  parameter int LEN_W    = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  input  logic [7:0] inByte,
  output logic       recValid,
  output logic       recHeader,
  output logic [7:0] recValue,
  output logic [1:0] recStatus,
  output logic       recPidErr,
  output logic       recSeqErr
);

  strobe_t strb;

  usbmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inEnd(inEnd), .inByte(inByte), .strb(strb)
  );

  usbmon_dpath #(.EP_COUNT(EP_COUNT), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .recValid(recValid), .recHeader(recHeader), .recValue(recValue),
    .recStatus(recStatus), .recPidErr(recPidErr), .recSeqErr(recSeqErr)
  );

endmodule

// File: tb/sim_usb_pkt_monitor.sv
`timescale 1ns/1ps
module sim_usb_pkt_monitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic [7:0] inByte = 8'd0;
  logic       recValid, recHeader, recPidErr, recSeqErr;
  logic [7:0] recValue;
  logic [1:0] recStatus;

  always #2.5 clk = ~clk;

  usb_pkt_monitor u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inEnd(inEnd), .inByte(inByte), .recValid(recValid),
    .recHeader(recHeader), .recValue(recValue), .recStatus(recStatus),
    .recPidErr(recPidErr), .recSeqErr(recSeqErr)
  );

  int    nCmp = 0, nBad = 0;
  bit    done = 0;
  string curReq = "R1";

  // expected record for the current cycle
  logic       eV = 0, eH = 0, ePe = 0, eSe = 0;
  logic [7:0] eVal = 0;
  logic [1:0] eSt = 0;

  // behavioural model state
  bit         mOpen = 0;
  logic [7:0] mPkt[$];
  bit         mTog[16];
  int         mEp = 0;
  logic [7:0] pk[$];

  function automatic logic [7:0] pidByte(input logic [3:0] p);
    return {~p, p};
  endfunction

  function automatic bit pidBadF(input logic [7:0] b);
    return (b[7:4] != ~b[3:0]) || (b[3:0] == 4'd0);
  endfunction

  function automatic logic [4:0] bCrc5(input logic [10:0] d);
    logic [4:0] c;
    logic fb;
    c = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      fb = d[i] ^ c[4];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    return c;
  endfunction

  function automatic logic [15:0] bCrc16(input int lo, input int hi);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int j = lo; j <= hi; j++)
      for (int i = 0; i < 8; i++) begin
        fb = pk[j][i] ^ c[15];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  function automatic bit tokGood();
    logic [4:0] c;
    bit ok;
    c = bCrc5({mPkt[2][2:0], mPkt[1]});
    ok = 1;
    for (int k = 0; k < 5; k++) if (mPkt[2][3+k] != ~c[4-k]) ok = 0;
    return ok;
  endfunction

  function automatic bit dataGood();
    logic [15:0] c;
    logic [7:0] a, b;
    bit ok;
    int n;
    n = mPkt.size();
    pk = mPkt;
    c = bCrc16(1, n - 3);
    a = mPkt[n-2];
    b = mPkt[n-1];
    ok = 1;
    for (int k = 0; k < 8; k++) begin
      if (a[k] != ~c[15-k]) ok = 0;
      if (b[k] != ~c[7-k]) ok = 0;
    end
    return ok;
  endfunction

  function automatic logic [1:0] mStatus();
    int n;
    logic [3:0] p;
    n = mPkt.size();
    p = mPkt[0][3:0];
    if (pidBadF(mPkt[0])) return 2'd3;
    case (p[1:0])
      2'b01: return (n != 3) ? 2'd3 : (tokGood() ? 2'd1 : 2'd2);
      2'b11: return (n < 3) ? 2'd3 : (dataGood() ? 2'd1 : 2'd2);
      2'b10: return (n == 1) ? 2'd1 : 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  task automatic mFinish();
    logic [3:0] p;
    logic [7:0] saved[$];
    p = mPkt[0][3:0];
    saved = pk;
    eSt = mStatus();
    pk = saved;
    if (eSt == 2'd1 && p[1:0] == 2'b01 && p != 4'b0101) begin
      mEp = {mPkt[2][2:0], mPkt[1][7]};
      if (p == 4'b1101) mTog[mEp] = 0;
    end
    if (eSt == 2'd1 && p[1:0] == 2'b11 && !p[2]) mTog[mEp] = ~p[3];
    mOpen = 0;
  endtask

  task automatic model(input logic v, s, e, input logic [7:0] b);
    eV = 0; eH = 0; ePe = 0; eSe = 0; eSt = 0; eVal = b;
    if (v && s) begin
      mPkt.delete();
      mPkt.push_back(b);
      mOpen = 1;
      eV = 1; eH = 1;
      ePe = pidBadF(b);
      if (!ePe && b[1:0] == 2'b11 && !b[2]) eSe = (b[3] != mTog[mEp]);
      if (e) mFinish();
    end else if (v && mOpen) begin
      mPkt.push_back(b);
      eV = 1;
      if (e) mFinish();
    end
  endtask

  task automatic check();
    bit bad;
    nCmp++;
    if (eV) bad = (recValid !== 1'b1) || (recHeader !== eH) || (recValue !== eVal) ||
                  (recStatus !== eSt) || (recPidErr !== ePe) || (recSeqErr !== eSe);
    else    bad = (recValid !== 1'b0);
    if (bad) begin
      nBad++;
      $display("FAIL %s t=%0t actual v=%b h=%b val=%h st=%0d pe=%b se=%b expected v=%b h=%b val=%h st=%0d pe=%b se=%b",
               curReq, $time, recValid, recHeader, recValue, recStatus, recPidErr, recSeqErr,
               eV, eH, eVal, eSt, ePe, eSe);
    end
  endtask

  task automatic tick(input logic v, s, e, input logic [7:0] b);
    @(negedge clk);
    check();
    inValid = v; inStart = s; inEnd = e; inByte = b;
    model(v, s, e, b);
  endtask

  task automatic sendPk(input int gapAt);
    for (int i = 0; i < pk.size(); i++) begin
      if (i == gapAt) tick(1'b0, 1'b0, 1'b0, 8'h00);
      tick(1'b1, i == 0, i == pk.size() - 1, pk[i]);
    end
    tick(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic mkToken(input logic [3:0] p, input logic [6:0] addr,
                         input logic [3:0] ep, input bit corrupt);
    logic [4:0] c, f;
    c = bCrc5({ep, addr});
    for (int k = 0; k < 5; k++) f[k] = ~c[4-k];
    if (corrupt) f[0] = ~f[0];
    pk.delete();
    pk.push_back(pidByte(p));
    pk.push_back({ep[0], addr});
    pk.push_back({f, ep[3:1]});
  endtask

  task automatic mkData(input logic [3:0] p, input int n, input int seed, input bit corrupt);
    logic [15:0] c;
    logic [7:0] a, b;
    pk.delete();
    pk.push_back(pidByte(p));
    for (int i = 0; i < n; i++) pk.push_back(8'((seed + i * 37) & 8'hFF));
    c = bCrc16(1, n);
    for (int k = 0; k < 8; k++) begin
      a[k] = ~c[15-k];
      b[k] = ~c[7-k];
    end
    if (corrupt) a[0] = ~a[0];
    pk.push_back(a);
    pk.push_back(b);
  endtask

  task automatic one(input logic [7:0] b);
    pk.delete();
    pk.push_back(b);
    sendPk(-1);
  endtask

  initial begin
    #500000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 8'h00);

    // R3: stray bytes outside a packet
    curReq = "R3";
    tick(1'b1, 1'b0, 1'b0, 8'hA5);
    tick(1'b1, 1'b0, 1'b1, 8'h5A);
    tick(1'b0, 1'b0, 1'b0, 8'h00);

    // R11 / R2: setup transaction on endpoint 0
    curReq = "R11";
    mkToken(4'b1101, 7'd5, 4'd0, 0); sendPk(-1);
    curReq = "R2";
    mkData(4'b0011, 8, 3, 0); sendPk(-1);
    one(pidByte(4'b0010));
    curReq = "R10";
    mkToken(4'b1001, 7'd5, 4'd0, 0); sendPk(-1);
    mkData(4'b1011, 2, 9, 0); sendPk(-1);

    // R10: out-of-step toggle on endpoint 3
    mkToken(4'b0001, 7'd5, 4'd3, 0); sendPk(-1);
    mkData(4'b1011, 4, 17, 0); sendPk(-1);
    mkToken(4'b0001, 7'd5, 4'd3, 0); sendPk(-1);
    mkData(4'b0011, 4, 21, 0); sendPk(-1);

    // R12: independent endpoints, SOF keeps endpoint
    curReq = "R12";
    mkToken(4'b0001, 7'd5, 4'd7, 0); sendPk(-1);
    mkToken(4'b0101, 7'h2A, 4'd9, 0); sendPk(-1);
    mkData(4'b0011, 3, 40, 0); sendPk(-1);
    mkToken(4'b1001, 7'd5, 4'd3, 0); sendPk(-1);
    mkData(4'b0011, 1, 44, 0); sendPk(-1);

    // R11: setup forces DATA0 on endpoint 3
    curReq = "R11";
    mkToken(4'b1101, 7'd5, 4'd3, 0); sendPk(-1);
    mkData(4'b0011, 8, 50, 0); sendPk(-1);

    // R6: bad CRC16 keeps expectation; empty payload; short packet
    curReq = "R6";
    mkToken(4'b0001, 7'd5, 4'd7, 0); sendPk(-1);
    mkData(4'b1011, 5, 60, 1); sendPk(-1);
    mkToken(4'b0001, 7'd5, 4'd7, 0); sendPk(-1);
    mkData(4'b1011, 5, 61, 0); sendPk(-1);
    mkData(4'b0011, 0, 0, 0); sendPk(-1);
    mkData(4'b0011, 0, 0, 0); void'(pk.pop_back()); sendPk(-1);

    // R5: token CRC and length
    curReq = "R5";
    mkToken(4'b1001, 7'd12, 4'd4, 1); sendPk(-1);
    mkToken(4'b1001, 7'd12, 4'd4, 0); void'(pk.pop_back()); sendPk(-1);
    mkToken(4'b0001, 7'd12, 4'd4, 0); pk.push_back(8'h11); sendPk(-1);
    mkToken(4'b0001, 7'd127, 4'd15, 0); sendPk(-1);

    // R7: handshakes
    curReq = "R7";
    one(pidByte(4'b1010));
    one(pidByte(4'b1110));
    one(pidByte(4'b0110));
    pk.delete(); pk.push_back(pidByte(4'b0010)); pk.push_back(8'h00); sendPk(-1);

    // R8: special packets
    curReq = "R8";
    one(pidByte(4'b1100));
    pk.delete(); pk.push_back(pidByte(4'b1000));
    pk.push_back(8'h12); pk.push_back(8'h34); pk.push_back(8'h56); sendPk(-1);

    // R4: bad PIDs
    curReq = "R4";
    one(8'h33);
    one(8'hF0);
    pk.delete(); pk.push_back(8'hD3); pk.push_back(8'h01); pk.push_back(8'h02); sendPk(-1);

    // R13: restart inside an open packet
    curReq = "R13";
    tick(1'b1, 1'b1, 1'b0, pidByte(4'b0011));
    tick(1'b1, 1'b0, 1'b0, 8'h77);
    tick(1'b1, 1'b1, 1'b1, pidByte(4'b0010));
    tick(1'b0, 1'b0, 1'b0, 8'h00);

    // R2: gaps inside a packet
    curReq = "R2";
    mkData(4'b0111, 6, 90, 0); sendPk(3);
    tick(1'b0, 1'b0, 1'b0, 8'h00);

    // R9: status only on last records, re-checked over a long packet
    curReq = "R9";
    mkData(4'b1111, 20, 101, 0); sendPk(10);
    tick(1'b0, 1'b0, 1'b0, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule